// File: doc/BRIEF.md
# Word-to-Byte Bus Cycle Splitter

This block sits between a 16-bit processor port and a byte-addressed system bus that can hold both 8-bit and 16-bit slaves. The processor side presents a word address, separate strobes for the upper and lower byte, a read/write flag, an interrupt-acknowledge flag and 16 bits of write data. The bus side carries a full byte address whose lowest bit is generated here, two separate byte lanes (an outbound lane and an inbound lane), a 16-bit request line, a 16-bit acknowledge line from the slave and a ready line that ends each bus cycle.

A word access raises the 16-bit request with an even address. If the slave acknowledges, the whole word moves in one bus cycle, with the even byte on the outbound lane and the odd byte on the inbound lane for writes, and the reverse for reads. If the slave stays silent, the block runs a second bus cycle at the odd address to move the remaining byte. The processor only gets its acknowledge after the last byte, so it never sees the split. Interrupt-acknowledge cycles follow the same two-cycle rule and keep only the second byte as the vector. A strap input selects a single-byte mode, in which the first byte read is the vector.

Byte order is big-endian: the even byte is data bits 15..8 and the odd byte is bits 7..0. A request is a one-cycle pulse of `cpu_req` taken only while the block is idle. `cpu_ack` is a one-cycle pulse that carries the read data.

Top module: `wsplit_bridge`

## Requirements
- R1: Bus address bits above bit 0 equal the processor word address for the whole transaction. Bit 0 is 0 for a word access, an upper-strobe-only access or an interrupt acknowledge, and it is 1 for a lower-strobe-only access and for every second bus cycle.
- R2: `bus_xreq` is high during the first bus cycle of a word access or of an interrupt acknowledge, and only with an even address. It is low during byte accesses and during second cycles.
- R3: An acknowledged word write takes one bus cycle. It drives write bits 15..8 on `bus_dout` and bits 7..0 on `bus_di_drv`.
- R4: An acknowledged word read takes one bus cycle and returns {`bus_din`, `bus_do_in`} as bits 15..8 and 7..0.
- R5: An unacknowledged word write takes two bus cycles. The first drives bits 15..8 on `bus_dout`. The second, with bit 0 of the address at 1, drives bits 7..0 (the byte first placed on `bus_di_drv`) on `bus_dout`.
- R6: An unacknowledged word read takes two bus cycles. It returns the first cycle's `bus_din` in bits 15..8 and the second cycle's `bus_din` in bits 7..0.
- R7: `cpu_ack` is a one-cycle pulse. It rises in the cycle after the final bus cycle ends (`bus_cyc` and `bus_rdy` both high), and low `bus_rdy` stretches each bus cycle. From the edge that samples `cpu_req` to the edge that raises `cpu_ack`, the count is 1 + n·(w+1) edges for n bus cycles of w wait cycles each.
- R8: Byte accesses take one bus cycle and ignore `bus_ack16`. An upper byte write drives bits 15..8 on `bus_dout`, and a lower byte write drives bits 7..0. A byte read places `bus_din` in the matching half of `cpu_rdata` and zeroes the other half.
- R9: With `iack_single` low, an interrupt acknowledge that is not acknowledged runs two read cycles, drops the first byte and returns {0, second byte}. If it is acknowledged, it returns {0, `bus_do_in`} after one cycle.
- R10: With `iack_single` high, an interrupt acknowledge runs one bus cycle even without `bus_ack16` and returns {0, `bus_din`}.
- R11: After reset, `bus_cyc`, `bus_start`, `bus_xreq` and `cpu_ack` are low. `bus_start` is high only in the first clock of each bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | One-cycle request pulse, taken while idle |
| cpu_addr | input | ADDR_W-1 | Processor word address (bits ADDR_W-1..1) |
| cpu_ub | input | 1 | Upper (even) byte strobe |
| cpu_lb | input | 1 | Lower (odd) byte strobe |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_iack | input | 1 | Interrupt-acknowledge access |
| cpu_wdata | input | 2*BYTE_W | Write data, even byte in the upper half |
| cpu_rdata | output | 2*BYTE_W | Read data, valid with cpu_ack |
| cpu_ack | output | 1 | Transaction complete pulse |
| iack_single | input | 1 | Strap: single-byte interrupt-acknowledge vector |
| bus_addr | output | ADDR_W | Byte address with generated bit 0 |
| bus_start | output | 1 | First clock of a bus cycle |
| bus_cyc | output | 1 | Bus cycle in progress |
| bus_wr | output | 1 | Bus cycle is a write |
| bus_xreq | output | 1 | 16-bit transfer request |
| bus_dout | output | BYTE_W | Outbound byte lane |
| bus_di_drv | output | BYTE_W | Odd byte driven onto the inbound lane during a word write |
| bus_din | input | BYTE_W | Inbound byte lane |
| bus_do_in | input | BYTE_W | Outbound lane read back during an acknowledged word read |
| bus_ack16 | input | 1 | Slave accepts a 16-bit transfer |
| bus_rdy | input | 1 | Ends the current bus cycle |

## Verification
The slave model answers each access in one of three ways: it acknowledges the 16-bit request, it stays an 8-bit slave, or it raises the acknowledge during a byte access where it must not matter. Reads return different bytes at the even and odd addresses, so a swapped lane or a missing second cycle shows up in the data. Word reads and writes, both single-strobe forms and all three interrupt-acknowledge variants are run. Wait counts of zero, one and two separate the per-cycle stretching from the number of bus cycles in the acknowledge latency.

// File: rtl/wsplit_pkg.sv
package wsplit_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CYC1 = 2'd1,
      ST_CYC2 = 2'd2,
      ST_DONE = 2'd3
   } wsplit_state_e;

   typedef enum logic [1:0] {
      K_WORD = 2'd0,
      K_EVEN = 2'd1,
      K_ODD  = 2'd2,
      K_IACK = 2'd3
   } wsplit_kind_e;
endpackage

// File: rtl/wsplit_ctrl.sv
module wsplit_ctrl
   import wsplit_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  wsplit_kind_e  kind,
   input  logic          iack_single,
   input  logic          bus_rdy,
   input  logic          bus_ack16,
   output wsplit_state_e state,
   output logic          bus_start,
   output logic          cyc_end
);
   wsplit_state_e nxt;
   logic          need_second;

   assign cyc_end     = ((state == ST_CYC1) || (state == ST_CYC2)) && bus_rdy;
   assign need_second = !bus_ack16 &&
                        ((kind == K_WORD) || ((kind == K_IACK) && !iack_single));

   always_comb begin
      nxt = state;
      case (state)
         ST_IDLE: if (start)   nxt = ST_CYC1;
         ST_CYC1: if (bus_rdy) nxt = need_second ? ST_CYC2 : ST_DONE;
         ST_CYC2: if (bus_rdy) nxt = ST_DONE;
         default:              nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         bus_start <= 1'b0;
      end else begin
         state     <= nxt;
         bus_start <= ((nxt == ST_CYC1) && (state != ST_CYC1)) ||
                      ((nxt == ST_CYC2) && (state != ST_CYC2));
      end
   end
endmodule

// File: rtl/wsplit_lanes.sv
module wsplit_lanes
   import wsplit_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int BYTE_W = 8,
   localparam int DATA_W = 2 * BYTE_W
) (
   input  wsplit_state_e     state,
   input  wsplit_kind_e      kind,
   input  logic              wr,
   input  logic [ADDR_W-1:1] word_addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_cyc,
   output logic              bus_wr,
   output logic              bus_xreq,
   output logic [BYTE_W-1:0] bus_dout,
   output logic [BYTE_W-1:0] bus_di_drv
);
   logic              first, second;
   logic [BYTE_W-1:0] even_b, odd_b;

   assign first   = (state == ST_CYC1);
   assign second  = (state == ST_CYC2);
   assign even_b  = wdata[DATA_W-1:BYTE_W];
   assign odd_b   = wdata[BYTE_W-1:0];
   assign bus_cyc = first || second;
   assign bus_wr  = bus_cyc && wr;

   always_comb begin
      bus_addr    = {word_addr, 1'b0};
      bus_addr[0] = second || (kind == K_ODD);
      bus_xreq    = first && ((kind == K_WORD) || (kind == K_IACK));
      bus_dout    = '0;
      bus_di_drv  = '0;
      if (bus_wr) begin
         if (second || (kind == K_ODD)) bus_dout = odd_b;
         else                           bus_dout = even_b;
         if (first && (kind == K_WORD)) bus_di_drv = odd_b;
      end
   end
endmodule

// File: rtl/wsplit_gather.sv
module wsplit_gather
   import wsplit_pkg::*;
#(
   parameter int BYTE_W = 8,
   localparam int DATA_W = 2 * BYTE_W,
   localparam int LANES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              cyc_end,
   input  logic              wr,
   input  wsplit_state_e     state,
   input  wsplit_kind_e      kind,
   input  logic              ack16,
   input  logic              iack_single,
   input  logic [BYTE_W-1:0] bus_din,
   input  logic [BYTE_W-1:0] bus_do_in,
   output logic [DATA_W-1:0] rdata
);
   // lane 1 holds the even byte (upper half), lane 0 the odd byte
   logic [LANES-1:0]  ld;
   logic [BYTE_W-1:0] src [LANES];

   always_comb begin
      ld     = '0;
      src[0] = bus_din;
      src[1] = bus_din;
      if (cyc_end && !wr) begin
         if (state == ST_CYC2) begin
            ld[0] = 1'b1;
         end else begin
            case (kind)
               K_WORD: begin
                  ld[1] = 1'b1;
                  if (ack16) begin
                     ld[0]  = 1'b1;
                     src[0] = bus_do_in;
                  end
               end
               K_EVEN: ld[1] = 1'b1;
               K_ODD:  ld[0] = 1'b1;
               default: begin
                  if (iack_single) begin
                     ld[0] = 1'b1;
                  end else if (ack16) begin
                     ld[0]  = 1'b1;
                     src[0] = bus_do_in;
                  end
               end
            endcase
         end
      end
   end

   for (genvar b = 0; b < LANES; b++) begin : g_lane
      logic [BYTE_W-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n || clear) q <= '0;
         else if (ld[b])      q <= src[b];
      end
      assign rdata[b*BYTE_W +: BYTE_W] = q;
   end
endmodule

// File: rtl/wsplit_bridge.sv
module wsplit_bridge
   import wsplit_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int BYTE_W = 8,
   localparam int DATA_W = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic [ADDR_W-1:1] cpu_addr,
   input  logic              cpu_ub,
   input  logic              cpu_lb,
   input  logic              cpu_wr,
   input  logic              cpu_iack,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_ack,
   input  logic              iack_single,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_start,
   output logic              bus_cyc,
   output logic              bus_wr,
   output logic              bus_xreq,
   output logic [BYTE_W-1:0] bus_dout,
   output logic [BYTE_W-1:0] bus_di_drv,
   input  logic [BYTE_W-1:0] bus_din,
   input  logic [BYTE_W-1:0] bus_do_in,
   input  logic              bus_ack16,
   input  logic              bus_rdy
);
   if (ADDR_W < 2) begin : g_bad_addr
      $error("wsplit_bridge: ADDR_W must be at least 2");
   end
   if (BYTE_W < 1) begin : g_bad_byte
      $error("wsplit_bridge: BYTE_W must be at least 1");
   end

   wsplit_state_e     state;
   wsplit_kind_e      kind_q, kind_in;
   logic              start, cyc_end, wr_q;
   logic [ADDR_W-1:1] addr_q;
   logic [DATA_W-1:0] wdata_q;

   assign start = (state == ST_IDLE) && cpu_req && (cpu_ub || cpu_lb || cpu_iack);

   always_comb begin
      if (cpu_iack)               kind_in = K_IACK;
      else if (cpu_ub && cpu_lb)  kind_in = K_WORD;
      else if (cpu_ub)            kind_in = K_EVEN;
      else                        kind_in = K_ODD;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kind_q  <= K_WORD;
         wr_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (start) begin
         kind_q  <= kind_in;
         wr_q    <= cpu_wr && !cpu_iack;
         addr_q  <= cpu_addr;
         wdata_q <= cpu_wdata;
      end
   end

   wsplit_ctrl u_ctrl (
      .clk, .rst_n, .start,
      .kind        (kind_q),
      .iack_single,
      .bus_rdy, .bus_ack16,
      .state, .bus_start, .cyc_end
   );

   wsplit_lanes #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_lanes (
      .state,
      .kind       (kind_q),
      .wr         (wr_q),
      .word_addr  (addr_q),
      .wdata      (wdata_q),
      .bus_addr, .bus_cyc, .bus_wr, .bus_xreq, .bus_dout, .bus_di_drv
   );

   wsplit_gather #(.BYTE_W(BYTE_W)) u_gather (
      .clk, .rst_n,
      .clear      (start),
      .cyc_end,
      .wr         (wr_q),
      .state,
      .kind       (kind_q),
      .ack16      (bus_ack16),
      .iack_single,
      .bus_din, .bus_do_in,
      .rdata      (cpu_rdata)
   );

   assign cpu_ack = (state == ST_DONE);
endmodule

// File: rtl/wsplit_chk.sv
module wsplit_chk #(
   parameter int ADDR_W = 24,
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_ack,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_start,
   input logic              bus_cyc,
   input logic              bus_wr,
   input logic              bus_xreq,
   input logic [BYTE_W-1:0] bus_di_drv,
   input logic              bus_rdy
);
   // R7
   ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ack |=> !cpu_ack);

   // R7
   ack_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ack |-> $past(bus_cyc && bus_rdy));

   // R2
   xreq_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_xreq |-> (bus_cyc && !bus_addr[0]));

   // R5
   second_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cyc && $past(bus_cyc && bus_rdy)) |-> (bus_addr[0] && !bus_xreq && bus_start));

   // R1
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cyc && $past(bus_cyc)) |-> $stable(bus_addr[ADDR_W-1:1]));

   // R11
   start_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_start |-> bus_cyc);

   // R3
   odd_lane_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_di_drv != '0) |-> (bus_xreq && bus_wr));
endmodule

bind wsplit_bridge wsplit_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (
   .clk, .rst_n, .cpu_ack, .bus_addr, .bus_start, .bus_cyc,
   .bus_wr, .bus_xreq, .bus_di_drv, .bus_rdy
);

// File: tb/wsplit_bridge_bench.sv
module wsplit_bridge_bench;
   localparam int AW = 24;
   localparam int BW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_req = 1'b0, cpu_ub = 1'b0, cpu_lb = 1'b0;
   logic          cpu_wr = 1'b0, cpu_iack = 1'b0, iack_single = 1'b0;
   logic [AW-1:1] cpu_addr = '0;
   logic [15:0]   cpu_wdata = '0;
   logic [15:0]   cpu_rdata;
   logic          cpu_ack;
   logic [AW-1:0] bus_addr;
   logic          bus_start, bus_cyc, bus_wr, bus_xreq;
   logic [7:0]    bus_dout, bus_di_drv;
   logic [7:0]    bus_din = '0, bus_do_in = '0;
   logic          bus_ack16 = 1'b0, bus_rdy = 1'b0;

   wsplit_bridge #(.ADDR_W(AW), .BYTE_W(BW)) u_wsplit_bridge (.*);

   always #10 clk = ~clk;

   int checks = 0, failures = 0, cyc_cnt = 0, ack_seen = 0, ack_at = 0;
   logic [15:0] exp_q[$];
   string       cur_tag;

   // slave model state
   logic [7:0]  s_even, s_odd;
   logic        s_ack16;
   int          s_wait, wcnt;
   int          nrec;
   logic [AW-1:0] rec_addr [4];
   logic        rec_x [4];
   logic [7:0]  rec_do [4];
   logic [7:0]  rec_dd [4];

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

   // slave responder
   always @(negedge clk) begin
      if (bus_cyc) begin
         if (bus_start) begin
            wcnt = 0;
            if (nrec < 4) begin
               rec_addr[nrec] = bus_addr;
               rec_x[nrec]    = bus_xreq;
               rec_do[nrec]   = bus_dout;
               rec_dd[nrec]   = bus_di_drv;
            end
            nrec++;
         end
         bus_rdy   <= (wcnt >= s_wait);
         wcnt++;
         bus_din   <= bus_addr[0] ? s_odd : s_even;
         bus_do_in <= s_odd;
         bus_ack16 <= s_ack16;
      end else begin
         bus_rdy   <= 1'b0;
         bus_ack16 <= 1'b0;
      end
   end

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && cpu_ack) begin
         if (exp_q.size() == 0) begin
            check({cur_tag, " unexpected ack"}, 1, 0);
         end else begin
            logic [15:0] e;
            e = exp_q.pop_front();
            check({cur_tag, " rdata"}, cpu_rdata, e);
         end
         ack_at = cyc_cnt;
         ack_seen++;
      end
   end

   task automatic xfer(input string tag, input logic [AW-1:1] wa, input logic ub, input logic lb,
                       input logic wr, input logic iack, input logic [15:0] wd,
                       input logic ack16, input int w, input logic [7:0] ev, input logic [7:0] od,
                       input logic [15:0] exp, input int ncyc);
      int t0, prev;
      logic a0;
      @(negedge clk);
      s_even = ev; s_odd = od; s_ack16 = ack16; s_wait = w; nrec = 0;
      cur_tag = tag;
      exp_q.push_back(exp);
      cpu_addr = wa; cpu_ub = ub; cpu_lb = lb; cpu_wr = wr; cpu_iack = iack; cpu_wdata = wd;
      cpu_req = 1'b1;
      t0 = cyc_cnt; prev = ack_seen;
      @(negedge clk);
      cpu_req = 1'b0;
      while (ack_seen == prev) @(negedge clk);
      check({tag, " R7 bus cycle count"}, nrec, ncyc);
      check({tag, " R7 ack latency"}, ack_at - t0, 1 + ncyc * (w + 1));
      a0 = !(iack || ub);
      check({tag, " R1 first address"}, rec_addr[0], {wa, a0});
      check({tag, " R2 first xreq"}, rec_x[0], (ub && lb) || iack);
      if (ncyc == 2) begin
         check({tag, " R1 second address"}, rec_addr[1], {wa, 1'b1});
         check({tag, " R2 second xreq"}, rec_x[1], 0);
      end
      @(negedge clk);
      check({tag, " R7 ack dropped"}, cpu_ack, 0);
   endtask

   initial begin : watchdog
      wait (cyc_cnt > 20000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      nrec = 0; s_wait = 0; s_ack16 = 0; s_even = 0; s_odd = 0; wcnt = 0;
      repeat (3) @(negedge clk);
      // R11 reset state
      check("R11 reset bus_cyc", bus_cyc, 0);
      check("R11 reset cpu_ack", cpu_ack, 0);
      check("R11 reset bus_xreq", bus_xreq, 0);
      check("R11 reset bus_start", bus_start, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R3 acknowledged word write
      xfer("R3 word write ack", 23'h012340, 1, 1, 1, 0, 16'hABCD, 1, 0, 8'h00, 8'h00, 16'h0000, 1);
      check("R3 even on dout", rec_do[0], 8'hAB);
      check("R3 odd on di lane", rec_dd[0], 8'hCD);

      // R5 split word write
      xfer("R5 word write split", 23'h000777, 1, 1, 1, 0, 16'h1E2F, 0, 1, 8'h00, 8'h00, 16'h0000, 2);
      check("R5 first dout even", rec_do[0], 8'h1E);
      check("R5 first di lane odd", rec_dd[0], 8'h2F);
      check("R5 second dout odd", rec_do[1], 8'h2F);
      check("R5 second di lane idle", rec_dd[1], 8'h00);

      // R4 acknowledged word read
      xfer("R4 word read ack", 23'h2AAAAA, 1, 1, 0, 0, 16'h0, 1, 0, 8'h5A, 8'h3C, 16'h5A3C, 1);

      // R6 split word read with waits
      xfer("R6 word read split", 23'h100001, 1, 1, 0, 0, 16'h0, 0, 2, 8'h91, 8'h47, 16'h9147, 2);

      // R8 byte writes and reads
      xfer("R8 upper byte write", 23'h000010, 1, 0, 1, 0, 16'hC3A5, 0, 0, 8'h00, 8'h00, 16'h0000, 1);
      check("R8 upper write dout", rec_do[0], 8'hC3);
      xfer("R8 lower byte write", 23'h000010, 0, 1, 1, 0, 16'hC3A5, 0, 1, 8'h00, 8'h00, 16'h0000, 1);
      check("R8 lower write dout", rec_do[0], 8'hA5);
      xfer("R8 upper byte read", 23'h000020, 1, 0, 0, 0, 16'h0, 0, 0, 8'h6E, 8'h11, 16'h6E00, 1);
      xfer("R8 lower byte read ack ignored", 23'h000020, 0, 1, 0, 0, 16'h0, 1, 0, 8'h6E, 8'h11, 16'h0011, 1);

      // R9 interrupt acknowledge, two bytes
      xfer("R9 iack two byte", 23'h7FFFF8, 0, 0, 0, 1, 16'h0, 0, 0, 8'hEE, 8'h42, 16'h0042, 2);
      xfer("R9 iack word ack", 23'h7FFFF8, 0, 0, 0, 1, 16'h0, 1, 1, 8'hEE, 8'h43, 16'h0043, 1);

      // R10 single-byte interrupt acknowledge
      iack_single = 1'b1;
      xfer("R10 iack single byte", 23'h7FFFF8, 0, 0, 0, 1, 16'h0, 0, 0, 8'h64, 8'h99, 16'h0064, 1);
      iack_single = 1'b0;

      // R6 again with one wait, distinct data, after single mode cleared
      xfer("R6 word read split w1", 23'h055555, 1, 1, 0, 0, 16'h0, 0, 1, 8'h0F, 8'hF0, 16'h0FF0, 2);

      check("R7 scoreboard drained", exp_q.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule